// File: doc/BRIEF.md
# Escape-Prefixed Opcode Predecoder

This block sits in front of an instruction decoder and turns a raw stream of 8-bit instruction bytes into one record per instruction. Bytes arrive on a valid/ready handshake, one per cycle at most. The block recognises the four escape bytes (0xCB, 0xED, 0xDD, 0xFD) and tracks which opcode group the instruction belongs to. It finds the opcode byte, places any displacement byte and assembles any immediate operand. It also counts how many bytes the instruction occupied.

Each finished instruction is presented as a held output record. The record carries the group tag, the opcode, the displacement, a 16-bit immediate, the length and an unknown flag. The record stays on the outputs until the consumer accepts it. In the same cycle that a record is accepted, the block can already take the first byte of the next instruction, so back-to-back one-byte instructions flow at one per cycle.

For the two index groups followed by 0xCB, the displacement comes before the opcode. Capture order therefore depends on the prefix pair.

Top module: `opcode_predecoder`

## Requirements
- R1: A synchronous active-high `rst` discards any partly collected instruction. While `rst` is high, and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1. The next byte accepted is treated as a first byte.
- R2: A first byte that is not an escape byte is an opcode in group 0, and its length is 1 plus its immediate byte count. The count is 2 for these opcodes: 0x01, 0x11, 0x21, 0x31, 0x22, 0x2A, 0x32, 0x3A, 0xC3, 0xCD, 11ccc010 and 11ccc100. The count is 1 for these opcodes: 00rrr110, 11aaa110, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0xD3 and 0xDB. Every other opcode has a count of 0.
- R3: After 0xCB, the next byte is the opcode. The record has group 1 and length 2, and no operand bytes follow.
- R4: After 0xED, the record has group 2. Opcodes 01xxxxxx and 101xx0xx are known, and all other opcodes are unknown. Opcodes 01xxx011 take a 2-byte immediate, which gives length 4. The other known opcodes have length 2.
- R5: After 0xDD the record has group 3, and after 0xFD it has group 4. Opcodes that reach memory through the index take one displacement byte, and it comes before any immediate byte. These opcodes are 0x34, 0x35, 0x36, 01rrr110, 01110rrr and 10aaa110, excluding 0x76. The opcodes 0x21, 0x22 and 0x2A take a 2-byte immediate, and 0x36 takes a 1-byte immediate. The opcodes 0x09, 0x19, 0x29, 0x39, 0x23, 0x2B, 0xE1, 0xE3, 0xE5, 0xE9 and 0xF9 are known and take no operand. All other opcodes are unknown.
- R6: For 0xDD then 0xCB, or 0xFD then 0xCB, the third byte is the displacement and the fourth byte is the opcode. The group is 5 for the 0xDD pair and 6 for the 0xFD pair, and the length is 4. The opcode is known only if its low three bits are 110.
- R7: A 2-byte immediate is taken low byte first. `out_imm[7:0]` holds the first immediate byte and `out_imm[15:8]` holds the second. A 1-byte immediate leaves `out_imm[15:8]` at 0.
- R8: For the relative-jump opcodes 0x10, 0x18, 0x20, 0x28, 0x30 and 0x38, `out_imm[15:8]` copies bit 7 of the operand, so `out_imm` is the signed offset.
- R9: An unknown opcode ends the instruction at that byte. The record has `out_unknown` set, `out_len` equal to 1 and the offending byte in `out_opcode`.
- R10: While `out_valid` is 1 and `out_ready` is 0, every record field holds steady and `in_ready` is 0.
- R11: In a cycle where a record is accepted, `in_ready` is 1, so a new byte can be taken in that same cycle.
- R12: Cycles with `in_valid` low neither advance nor corrupt a partly collected instruction, and they produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_ready | output | 1 | Byte taken this cycle when both are high |
| in_byte | input | 8 | Instruction byte |
| out_valid | output | 1 | Record available |
| out_ready | input | 1 | Consumer takes the record |
| out_group | output | 3 | Group tag 0..6 (see R2-R6) |
| out_opcode | output | 8 | Opcode byte |
| out_disp | output | 8 | Displacement byte, 0 when absent |
| out_imm | output | 16 | Immediate value, 0 when absent |
| out_len | output | 3 | Instruction length in bytes |
| out_unknown | output | 1 | Opcode matched no known form |

## Verification
The two functions that can fall in the same cycle are the hand-off of a finished record and the intake of the first byte of the next instruction. The bench provokes this by streaming one-byte and multi-byte instructions back-to-back while `out_ready` is held high. It judges the result in two ways. First, every cycle that delivers a record must also show `in_ready` high. Second, a run of one-byte instructions must drain in about one cycle each, and every record must still match the scoreboard. A second pass drives `out_ready` from a pseudo-random sequence and puts idle gaps between the input bytes. This pass checks that a held record never changes and that no byte slips in while the record is blocked.

// File: rtl/predec_pkg.sv
package predec_pkg;

    localparam int BYTE_W  = 8;
    localparam int MAX_LEN = 4;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int IMM_W   = 2 * BYTE_W;
    localparam int LEFT_W  = $clog2(MAX_LEN);

    localparam logic [BYTE_W-1:0] ESC_BIT  = 8'hCB;
    localparam logic [BYTE_W-1:0] ESC_MISC = 8'hED;
    localparam logic [BYTE_W-1:0] ESC_IX   = 8'hDD;
    localparam logic [BYTE_W-1:0] ESC_IY   = 8'hFD;

    typedef enum logic [2:0] {
        GRP_BASE  = 3'd0,
        GRP_BIT   = 3'd1,
        GRP_MISC  = 3'd2,
        GRP_IX    = 3'd3,
        GRP_IY    = 3'd4,
        GRP_IXBIT = 3'd5,
        GRP_IYBIT = 3'd6
    } grp_e;

    typedef enum logic [2:0] {
        ST_FIRST  = 3'd0,
        ST_SECOND = 3'd1,
        ST_XDISP  = 3'd2,
        ST_XOP    = 3'd3,
        ST_OPND   = 3'd4,
        ST_HOLD   = 3'd5
    } st_e;

    typedef struct packed {
        logic              known;
        logic              need_disp;
        logic [LEFT_W-1:0] imm_cnt;
        logic              rel;
    } opinfo_t;

    typedef struct packed {
        st_e               st;
        grp_e              grp;
        logic [BYTE_W-1:0] opc;
        logic [BYTE_W-1:0] disp;
        logic [IMM_W-1:0]  imm;
        logic [LEN_W-1:0]  cnt;
        logic              unk;
        logic              disp_pend;
        logic              rel;
        logic              imm_hi;
        logic [LEFT_W-1:0] left;
    } seq_t;

endpackage

// File: rtl/predec_classify.sv
module predec_classify
    import predec_pkg::*;
(
    input  grp_e              grp,
    input  logic [BYTE_W-1:0] opc,
    output opinfo_t           info
);

    logic base_imm2, base_imm1, base_rel;
    logic misc_known, misc_imm2;
    logic idx_mem, idx_plain, idx_imm2, idx_imm1;
    logic not_halt;

    always_comb begin
        // group 0 operand sizes
        base_rel  = (opc[7:6] == 2'b00) && (opc[2:0] == 3'b000) && (opc[5:4] != 2'b00);
        base_imm2 = ((opc[7:6] == 2'b00) && (opc[3:0] == 4'h1))
                 || (opc == 8'h22) || (opc == 8'h2A) || (opc == 8'h32) || (opc == 8'h3A)
                 || (opc == 8'hC3) || (opc == 8'hCD)
                 || ((opc[7:6] == 2'b11) && (opc[2:0] == 3'b010))
                 || ((opc[7:6] == 2'b11) && (opc[2:0] == 3'b100));
        base_imm1 = ((opc[7:6] == 2'b00) && (opc[2:0] == 3'b110))
                 || ((opc[7:6] == 2'b11) && (opc[2:0] == 3'b110))
                 || base_rel || (opc == 8'hD3) || (opc == 8'hDB);

        // miscellaneous group
        misc_known = (opc[7:6] == 2'b01) || ((opc[7:5] == 3'b101) && !opc[2]);
        misc_imm2  = (opc[7:6] == 2'b01) && (opc[2:0] == 3'b011);

        // index groups
        not_halt  = (opc != 8'h76);
        idx_mem   = (opc == 8'h34) || (opc == 8'h35) || (opc == 8'h36)
                 || ((opc[7:6] == 2'b01) && (opc[2:0] == 3'b110) && not_halt)
                 || ((opc[7:3] == 5'b01110) && not_halt)
                 || ((opc[7:6] == 2'b10) && (opc[2:0] == 3'b110));
        idx_plain = (opc == 8'h09) || (opc == 8'h19) || (opc == 8'h29) || (opc == 8'h39)
                 || (opc == 8'h21) || (opc == 8'h22) || (opc == 8'h23) || (opc == 8'h2A)
                 || (opc == 8'h2B) || (opc == 8'hE1) || (opc == 8'hE3) || (opc == 8'hE5)
                 || (opc == 8'hE9) || (opc == 8'hF9);
        idx_imm2  = (opc == 8'h21) || (opc == 8'h22) || (opc == 8'h2A);
        idx_imm1  = (opc == 8'h36);

        info = '0;
        unique case (grp)
            GRP_BASE: begin
                info.known   = 1'b1;
                info.rel     = base_rel;
                info.imm_cnt = base_imm2 ? LEFT_W'(2) : (base_imm1 ? LEFT_W'(1) : LEFT_W'(0));
            end
            GRP_BIT: begin
                info.known = 1'b1;
            end
            GRP_MISC: begin
                info.known   = misc_known;
                info.imm_cnt = (misc_known && misc_imm2) ? LEFT_W'(2) : LEFT_W'(0);
            end
            GRP_IX, GRP_IY: begin
                info.known     = idx_mem || idx_plain;
                info.need_disp = idx_mem;
                info.imm_cnt   = idx_imm2 ? LEFT_W'(2) : (idx_imm1 ? LEFT_W'(1) : LEFT_W'(0));
            end
            GRP_IXBIT, GRP_IYBIT: begin
                info.known = (opc[2:0] == 3'b110);
            end
            default: info = '0;
        endcase
    end

endmodule

// File: rtl/predec_seq.sv
module predec_seq
    import predec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output grp_e              cls_grp,
    input  opinfo_t           info,
    output logic              out_valid,
    input  logic              out_ready,
    output grp_e              out_group,
    output logic [BYTE_W-1:0] out_opcode,
    output logic [BYTE_W-1:0] out_disp,
    output logic [IMM_W-1:0]  out_imm,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_unknown
);

    seq_t r_q, r_d;
    st_e  st_eff;
    logic take;

    // a released record frees the sequencer for a first byte in the same cycle
    assign st_eff   = ((r_q.st == ST_HOLD) && out_ready) ? ST_FIRST : r_q.st;
    assign in_ready = (r_q.st != ST_HOLD) || out_ready;
    assign take     = in_valid && in_ready;
    assign cls_grp  = (st_eff == ST_FIRST) ? GRP_BASE : r_q.grp;

    always_comb begin
        logic       fin;
        logic [LEFT_W-1:0] need;
        r_d  = r_q;
        fin  = 1'b0;
        need = '0;
        if (st_eff != r_q.st) begin
            r_d.st = ST_FIRST;
        end
        if (take) begin
            r_d.cnt = r_q.cnt + 1'b1;
            unique case (st_eff)
                ST_FIRST: begin
                    r_d.cnt       = LEN_W'(1);
                    r_d.opc       = '0;
                    r_d.disp      = '0;
                    r_d.imm       = '0;
                    r_d.unk       = 1'b0;
                    r_d.rel       = 1'b0;
                    r_d.imm_hi    = 1'b0;
                    r_d.disp_pend = 1'b0;
                    r_d.left      = '0;
                    r_d.st        = ST_SECOND;
                    if (in_byte == ESC_BIT) begin
                        r_d.grp = GRP_BIT;
                    end else if (in_byte == ESC_MISC) begin
                        r_d.grp = GRP_MISC;
                    end else if (in_byte == ESC_IX) begin
                        r_d.grp = GRP_IX;
                    end else if (in_byte == ESC_IY) begin
                        r_d.grp = GRP_IY;
                    end else begin
                        r_d.grp = GRP_BASE;
                        r_d.opc = in_byte;
                        fin     = 1'b1;
                    end
                end
                ST_SECOND: begin
                    if (((r_q.grp == GRP_IX) || (r_q.grp == GRP_IY)) && (in_byte == ESC_BIT)) begin
                        r_d.grp = (r_q.grp == GRP_IX) ? GRP_IXBIT : GRP_IYBIT;
                        r_d.st  = ST_XDISP;
                    end else begin
                        r_d.opc = in_byte;
                        fin     = 1'b1;
                    end
                end
                ST_XDISP: begin
                    r_d.disp = in_byte;
                    r_d.st   = ST_XOP;
                end
                ST_XOP: begin
                    r_d.opc = in_byte;
                    fin     = 1'b1;
                end
                ST_OPND: begin
                    if (r_q.disp_pend) begin
                        r_d.disp      = in_byte;
                        r_d.disp_pend = 1'b0;
                    end else if (!r_q.imm_hi) begin
                        r_d.imm[BYTE_W-1:0] = in_byte;
                        if (r_q.rel) begin
                            r_d.imm[IMM_W-1:BYTE_W] = {BYTE_W{in_byte[BYTE_W-1]}};
                        end
                        r_d.imm_hi = 1'b1;
                    end else begin
                        r_d.imm[IMM_W-1:BYTE_W] = in_byte;
                    end
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == LEFT_W'(1)) begin
                        r_d.st = ST_HOLD;
                    end
                end
                default: r_d.st = ST_FIRST;
            endcase
        end
        if (fin) begin
            if (!info.known) begin
                r_d.unk = 1'b1;
                r_d.st  = ST_HOLD;
            end else begin
                need          = LEFT_W'(info.need_disp) + info.imm_cnt;
                r_d.disp_pend = info.need_disp;
                r_d.rel       = info.rel;
                r_d.left      = need;
                r_d.st        = (need == '0) ? ST_HOLD : ST_OPND;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q     <= '0;
            r_q.st  <= ST_FIRST;
            r_q.grp <= GRP_BASE;
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid   = (r_q.st == ST_HOLD);
    assign out_group   = r_q.grp;
    assign out_opcode  = r_q.opc;
    assign out_disp    = r_q.disp;
    assign out_imm     = r_q.imm;
    assign out_len     = r_q.unk ? LEN_W'(1) : r_q.cnt;
    assign out_unknown = r_q.unk;

endmodule

// File: rtl/opcode_predecoder.sv
module opcode_predecoder
    import predec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [2:0]        out_group,
    output logic [BYTE_W-1:0] out_opcode,
    output logic [BYTE_W-1:0] out_disp,
    output logic [IMM_W-1:0]  out_imm,
    output logic [LEN_W-1:0]  out_len,
    output logic              out_unknown
);

    grp_e    cls_grp;
    grp_e    grp_out;
    opinfo_t info;

    predec_classify u_classify (
        .grp  (cls_grp),
        .opc  (in_byte),
        .info (info)
    );

    predec_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_byte     (in_byte),
        .cls_grp     (cls_grp),
        .info        (info),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_group   (grp_out),
        .out_opcode  (out_opcode),
        .out_disp    (out_disp),
        .out_imm     (out_imm),
        .out_len     (out_len),
        .out_unknown (out_unknown)
    );

    assign out_group = grp_out;

endmodule

// File: rtl/predec_chk.sv
module predec_chk
    import predec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [2:0]        out_group,
    input logic [BYTE_W-1:0] out_opcode,
    input logic [BYTE_W-1:0] out_disp,
    input logic [IMM_W-1:0]  out_imm,
    input logic [LEN_W-1:0]  out_len,
    input logic              out_unknown
);

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && in_ready));

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_group) && $stable(out_opcode)
            && $stable(out_disp) && $stable(out_imm) && $stable(out_len) && $stable(out_unknown)));

    a_r10_blocked_intake: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready);

    a_r11_release_takes_byte: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready) |-> in_ready);

    a_r9_unknown_len: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_unknown) |-> (out_len == LEN_W'(1)));

    a_r3_bit_len: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_group == 3'd1)) |-> (out_len == LEN_W'(2)));

    a_r6_pair_len: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_unknown && ((out_group == 3'd5) || (out_group == 3'd6)))
            |-> (out_len == LEN_W'(4)));

    a_r2_len_bound: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_len >= LEN_W'(1)) && (out_len <= LEN_W'(MAX_LEN))));

    a_r12_idle_no_record: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !out_valid) |=> !out_valid);

endmodule

bind opcode_predecoder predec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_group   (out_group),
    .out_opcode  (out_opcode),
    .out_disp    (out_disp),
    .out_imm     (out_imm),
    .out_len     (out_len),
    .out_unknown (out_unknown)
);

// File: tb/opcode_predecoder_test.sv
`timescale 1ns/1ps
module opcode_predecoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [2:0]  out_group;
    logic [7:0]  out_opcode;
    logic [7:0]  out_disp;
    logic [15:0] out_imm;
    logic [2:0]  out_len;
    logic        out_unknown;

    int checks = 0;
    int errors = 0;
    int mode = 0;
    int gap = 0;
    int cyc = 0;
    logic [7:0] lfsr = 8'hA5;

    typedef struct {
        logic [2:0]  g;
        logic [7:0]  op;
        logic [7:0]  dp;
        logic [15:0] im;
        logic [2:0]  ln;
        logic        un;
        string       tag;
    } rec_t;

    rec_t exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    opcode_predecoder uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
        .out_valid(out_valid), .out_ready(out_ready), .out_group(out_group),
        .out_opcode(out_opcode), .out_disp(out_disp), .out_imm(out_imm),
        .out_len(out_len), .out_unknown(out_unknown)
    );

    task automatic check(input bit ok, input string tag, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s", tag, msg);
        end
    endtask

    // monitor: drives out_ready, checks hold behaviour and pops the scoreboard
    initial begin
        logic        held;
        logic [44:0] snap;
        held = 1'b0;
        snap = '0;
        forever begin
            @(negedge clk);
            out_ready = (mode == 0) ? 1'b1 : lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            #1;
            if (rst) begin
                held = 1'b0;
            end else begin
                if (held && out_valid)
                    check({out_group, out_opcode, out_disp, out_imm, out_len, out_unknown} == snap,
                          "R10", $sformatf("record changed while held: actual %h expected %h",
                          {out_group, out_opcode, out_disp, out_imm, out_len, out_unknown}, snap));
                if (out_valid && !out_ready)
                    check(in_ready == 1'b0, "R10",
                          $sformatf("in_ready actual %0b expected 0 while blocked", in_ready));
                held = out_valid && !out_ready;
                snap = {out_group, out_opcode, out_disp, out_imm, out_len, out_unknown};
                if (out_valid && out_ready) begin
                    check(in_ready == 1'b1, "R11",
                          $sformatf("in_ready actual %0b expected 1 on release", in_ready));
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R12", "record with none expected: actual 1 expected 0");
                    end else begin
                        rec_t e;
                        e = exp_q.pop_front();
                        check((out_group == e.g) && (out_opcode == e.op) && (out_disp == e.dp)
                              && (out_imm == e.im) && (out_len == e.ln) && (out_unknown == e.un),
                              e.tag,
                              $sformatf("actual g%0d op%h d%h i%h l%0d u%0b expected g%0d op%h d%h i%h l%0d u%0b",
                                        out_group, out_opcode, out_disp, out_imm, out_len, out_unknown,
                                        e.g, e.op, e.dp, e.im, e.ln, e.un));
                    end
                end
            end
        end
    end

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic instr(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input logic [7:0] b3,
                         input logic [2:0] g, input logic [7:0] op, input logic [7:0] dp,
                         input logic [15:0] im, input logic [2:0] ln, input logic un,
                         input string tag);
        rec_t e;
        logic [7:0] bs [4];
        e.g = g; e.op = op; e.dp = dp; e.im = im; e.ln = ln; e.un = un; e.tag = tag;
        exp_q.push_back(e);
        bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
        for (int i = 0; i < n; i++) send_byte(bs[i]);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_all();
        instr(1, 8'h00, 0, 0, 0, 3'd0, 8'h00, 8'h00, 16'h0000, 3'd1, 1'b0, "R2");
        instr(3, 8'h01, 8'h34, 8'h12, 0, 3'd0, 8'h01, 8'h00, 16'h1234, 3'd3, 1'b0, "R7");
        instr(2, 8'h3E, 8'h5A, 0, 0, 3'd0, 8'h3E, 8'h00, 16'h005A, 3'd2, 1'b0, "R7");
        instr(2, 8'h18, 8'hFE, 0, 0, 3'd0, 8'h18, 8'h00, 16'hFFFE, 3'd2, 1'b0, "R8");
        instr(2, 8'h10, 8'h05, 0, 0, 3'd0, 8'h10, 8'h00, 16'h0005, 3'd2, 1'b0, "R8");
        instr(3, 8'hC2, 8'h00, 8'h80, 0, 3'd0, 8'hC2, 8'h00, 16'h8000, 3'd3, 1'b0, "R2");
        instr(3, 8'hCD, 8'h78, 8'h56, 0, 3'd0, 8'hCD, 8'h00, 16'h5678, 3'd3, 1'b0, "R2");
        instr(2, 8'hFE, 8'h90, 0, 0, 3'd0, 8'hFE, 8'h00, 16'h0090, 3'd2, 1'b0, "R2");
        instr(2, 8'hD3, 8'h44, 0, 0, 3'd0, 8'hD3, 8'h00, 16'h0044, 3'd2, 1'b0, "R2");
        instr(1, 8'h47, 0, 0, 0, 3'd0, 8'h47, 8'h00, 16'h0000, 3'd1, 1'b0, "R2");
        instr(2, 8'hCB, 8'h47, 0, 0, 3'd1, 8'h47, 8'h00, 16'h0000, 3'd2, 1'b0, "R3");
        instr(2, 8'hCB, 8'hCB, 0, 0, 3'd1, 8'hCB, 8'h00, 16'h0000, 3'd2, 1'b0, "R3");
        instr(2, 8'hED, 8'h44, 0, 0, 3'd2, 8'h44, 8'h00, 16'h0000, 3'd2, 1'b0, "R4");
        instr(4, 8'hED, 8'h4B, 8'h34, 8'h12, 3'd2, 8'h4B, 8'h00, 16'h1234, 3'd4, 1'b0, "R4");
        instr(2, 8'hED, 8'hB0, 0, 0, 3'd2, 8'hB0, 8'h00, 16'h0000, 3'd2, 1'b0, "R4");
        instr(2, 8'hED, 8'h00, 0, 0, 3'd2, 8'h00, 8'h00, 16'h0000, 3'd1, 1'b1, "R9");
        instr(4, 8'hDD, 8'h21, 8'hCD, 8'hAB, 3'd3, 8'h21, 8'h00, 16'hABCD, 3'd4, 1'b0, "R5");
        instr(3, 8'hDD, 8'h7E, 8'h05, 0, 3'd3, 8'h7E, 8'h05, 16'h0000, 3'd3, 1'b0, "R5");
        instr(4, 8'hFD, 8'h36, 8'h80, 8'h99, 3'd4, 8'h36, 8'h80, 16'h0099, 3'd4, 1'b0, "R5");
        instr(2, 8'hDD, 8'h09, 0, 0, 3'd3, 8'h09, 8'h00, 16'h0000, 3'd2, 1'b0, "R5");
        instr(2, 8'hFD, 8'hE9, 0, 0, 3'd4, 8'hE9, 8'h00, 16'h0000, 3'd2, 1'b0, "R5");
        instr(4, 8'hDD, 8'hCB, 8'h10, 8'h46, 3'd5, 8'h46, 8'h10, 16'h0000, 3'd4, 1'b0, "R6");
        instr(4, 8'hFD, 8'hCB, 8'hF0, 8'hCE, 3'd6, 8'hCE, 8'hF0, 16'h0000, 3'd4, 1'b0, "R6");
        instr(4, 8'hDD, 8'hCB, 8'h01, 8'h47, 3'd5, 8'h47, 8'h01, 16'h0000, 3'd1, 1'b1, "R9");
        instr(2, 8'hDD, 8'h00, 0, 0, 3'd3, 8'h00, 8'h00, 16'h0000, 3'd1, 1'b1, "R9");
        instr(1, 8'h76, 0, 0, 0, 3'd0, 8'h76, 8'h00, 16'h0000, 3'd1, 1'b0, "R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #3;
        check(!out_valid && in_ready, "R1",
              $sformatf("after reset actual v%0b r%0b expected v0 r1", out_valid, in_ready));
        @(negedge clk);

        // abandon a partly collected instruction with reset
        send_byte(8'hDD);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #3;
        check(!out_valid && in_ready, "R1",
              $sformatf("mid reset actual v%0b r%0b expected v0 r1", out_valid, in_ready));
        @(negedge clk);
        instr(1, 8'h00, 0, 0, 0, 3'd0, 8'h00, 8'h00, 16'h0000, 3'd1, 1'b0, "R1");
        drain();

        // back-to-back one-byte records drain at one per cycle
        begin
            int t0;
            t0 = cyc;
            for (int i = 0; i < 6; i++)
                instr(1, 8'h00, 0, 0, 0, 3'd0, 8'h00, 8'h00, 16'h0000, 3'd1, 1'b0, "R11");
            while (exp_q.size() != 0) @(negedge clk);
            check((cyc - t0) <= 8, "R11",
                  $sformatf("six records took actual %0d cycles expected <= 8", cyc - t0));
        end
        drain();

        mode = 0; gap = 0;
        run_all();
        drain();

        mode = 1; gap = 1;
        run_all();
        drain();

        mode = 1; gap = 3;
        instr(4, 8'hFD, 8'hCB, 8'h7F, 8'h86, 3'd6, 8'h86, 8'h7F, 16'h0000, 3'd4, 1'b0, "R12");
        instr(3, 8'h2A, 8'hEF, 8'hBE, 0, 3'd0, 8'h2A, 8'h00, 16'hBEEF, 3'd3, 1'b0, "R12");
        drain();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule